// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the management-port master for an Ethernet PHY. Software programs a configuration word once: a speed value that sets the MDC half period in system clocks, and a hold value that sets how long MDIO keeps its old value after each MDC fall. A single write to the frame register then starts a complete serial transaction. The block sends 32 preamble ones and then the 32 frame bits, MSB first. For a read it releases MDIO for the turnaround and data bits and shifts in the PHY's reply. When the frame ends, the block raises a sticky event flag and MDC goes quiet.

Three register selects form the interface. Select 0 is the frame register, which can be written and is always visible on `frame_q`. Select 1 is the configuration word. Select 2 clears the event when bit 0 of the written data is one. After a read, the low half of the frame register holds the PHY data. The speed value is the system clock over 5 MHz, plus one. This rounds up, so MDC stays at or below 2.5 MHz.

Top module: `mdio_frame_master`

## Requirements
- R1: A frame is 32 ones on `mdio_o` followed by the frame register sent MSB first, one bit per MDC period: bits [31:30] start code (01), [29:28] operation (01 write, 10 read), [27:23] PHY address, [22:18] register address, [17:16] turnaround (10), [15:0] data.
- R2: MDC is low when idle. During a frame its low and high phases each last `half` system clocks, where `half` is the speed value, or 2 when the speed value is 1. A frame has exactly 64 MDC rising edges.
- R3: When the operation bits are 10, `mdio_oe` goes low from frame bit 15 (the second turnaround bit) through the end of the frame. The 16 bits sampled on the MDC rising edges of frame bits 16..31 are taken MSB first and placed in `frame_q[15:0]` when the frame completes. `frame_q[31:16]` is unchanged.
- R4: Within a frame, `mdio_o` changes exactly `h+1` system clocks after an MDC fall, where `h` = min(hold, half-2). `mdio_o` never changes while MDC is high.
- R5: The event output goes high in the cycle the frame ends and stays high. A write with select 2 and data bit 0 set clears it. A write with select 2 and data bit 0 clear leaves it set.
- R6: While the speed value is 0, MDC stays low and the frame makes no progress. It resumes when a nonzero speed is written.
- R7: A frame-register write while a frame is in progress is ignored. The frame on the wire and `frame_q` stay those of the running frame.
- R8: After reset, and after each frame, `mdc` is low, `mdio_oe` is low and `mdio_o` is high. After reset, `frame_q` and the event are zero.
- R9: A write with select 1 loads the speed from data bits [5:0] and the hold from data bits [10:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 frame, 1 config, 2 event clear |
| reg_wdata | input | 32 | Write data |
| frame_q | output | 32 | Frame register contents |
| mii_event | output | 1 | Frame-complete event flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high drives the pin) |
| mdio_i | input | 1 | MDIO pin value from the PHY |

## Verification
The bench runs write and read frames at several speeds. One of them uses speed 1, to check that a design without the minimum half period does not squeeze MDC down to a one-clock phase. It also uses hold values larger than the phase allows; a missing clamp would move `mdio_o` while MDC is high, or never update it at all. For reads, it checks that MDIO is released exactly at the second turnaround bit. It also checks that the final sampled bit reaches `frame_q`; a design that wrote the reply back one shift early would lose the LSB. Three more tests cover a stalled frame at speed 0, a frame write in the middle of a frame (which must not restart or corrupt it), and an event clear written with bit 0 at zero (which must not clear the event).

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int SPEED_W  = 6,
  parameter int HOLD_W   = 3,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] frame_q,
  output logic        mii_event,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TOTAL   = PRE_BITS + 32;
  localparam int BIT_W   = $clog2(TOTAL);
  localparam int REL_IDX = PRE_BITS + 15;
  localparam int DAT_IDX = PRE_BITS + 16;

  logic [SPEED_W-1:0] spd, half, hold_lim, hold_eff, cnt;
  logic [HOLD_W-1:0]  hold;
  logic [31:0]        fr;
  logic [15:0]        rd_sh, rd_next;
  logic [BIT_W-1:0]   bitn;
  logic [TOTAL-1:0]   tx_vec;
  logic busy, rd_op, ph, dout, oe, evt;
  logic phase_end, sample, done, launch, clr_evt;

  assign half     = (spd == SPEED_W'(1)) ? SPEED_W'(2) : spd;
  assign hold_lim = half - SPEED_W'(2);
  assign hold_eff = (SPEED_W'(hold) > hold_lim) ? hold_lim : SPEED_W'(hold);
  assign tx_vec   = {{PRE_BITS{1'b1}}, fr};

  assign phase_end = busy && (spd != '0) && (cnt >= half - SPEED_W'(1));
  assign sample    = busy && (spd != '0) && ph && (cnt == '0) && rd_op &&
                     (bitn >= BIT_W'(DAT_IDX));
  assign rd_next   = sample ? {rd_sh[14:0], mdio_i} : rd_sh;
  assign done      = phase_end && ph && (bitn == BIT_W'(TOTAL - 1));
  assign launch    = reg_wr && (reg_sel == 2'd0) && !busy;
  assign clr_evt   = reg_wr && (reg_sel == 2'd2) && reg_wdata[0];

  assign frame_q   = fr;
  assign mii_event = evt;
  assign mdc       = ph;
  assign mdio_o    = dout;
  assign mdio_oe   = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd   <= '0;
      hold  <= '0;
      fr    <= '0;
      busy  <= 1'b0;
      rd_op <= 1'b0;
      ph    <= 1'b0;
      cnt   <= '0;
      bitn  <= '0;
      rd_sh <= '0;
      dout  <= 1'b1;
      oe    <= 1'b0;
      evt   <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == 2'd1) begin
        spd  <= reg_wdata[SPEED_W-1:0];
        hold <= reg_wdata[8 +: HOLD_W];
      end

      if (done)         evt <= 1'b1;
      else if (clr_evt) evt <= 1'b0;

      if (!busy) begin
        if (launch) begin
          fr    <= reg_wdata;
          busy  <= 1'b1;
          rd_op <= (reg_wdata[29:28] == 2'b10);
          ph    <= 1'b0;
          cnt   <= '0;
          bitn  <= '0;
          dout  <= 1'b1;
          oe    <= 1'b1;
        end
      end else if (spd == '0) begin
        ph <= 1'b0;
      end else begin
        if (phase_end) begin
          cnt <= '0;
          ph  <= ~ph;
          if (ph) begin
            if (done) begin
              busy <= 1'b0;
              oe   <= 1'b0;
              dout <= 1'b1;
              if (rd_op) fr[15:0] <= rd_next;
            end else begin
              bitn <= bitn + BIT_W'(1);
            end
          end
        end else begin
          cnt <= cnt + SPEED_W'(1);
        end
        if (!ph && cnt == hold_eff) begin
          dout <= tx_vec[BIT_W'(TOTAL - 1) - bitn];
          oe   <= !(rd_op && bitn >= BIT_W'(REL_IDX));
        end
        rd_sh <= rd_next;
      end
    end
  end
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int SPEED_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic               mii_event,
  input logic               busy,
  input logic [SPEED_W-1:0] spd,
  input logic [31:0]        frame_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe && mdio_o)); // R8

  AST_EVENT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_event) |-> $fell(busy)); // R5

  AST_HOLD_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o)); // R4

  AST_SPEED_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (spd == '0 && $past(spd) == '0) |-> !mdc); // R6

  AST_FRAME_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_q) |-> ($fell(busy) || !$past(busy))); // R7

  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy); // R2
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.SPEED_W(SPEED_W)) u_chk (.*);

// File: tb/mdio_frame_master_test.sv
`timescale 1ns/1ps
module mdio_frame_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] frame_q;
  logic        mii_event, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int errors = 0, checks = 0, cyc = 0;
  int rises = 0, fall_cyc = 0, dmin = 99, dmax = 0, r1c = 0, r2c = 0;
  logic [63:0] cap, oecap;
  logic [15:0] phy_data = '0;
  bit finished = 0;

  mdio_frame_master uut (.*);

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc = cyc + 1;

  always @(posedge mdc) begin
    if (rises < 64) begin
      cap[63-rises]   = mdio_o;
      oecap[63-rises] = mdio_oe;
    end
    if (rises == 0) r1c = cyc;
    if (rises == 1) r2c = cyc;
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    fall_cyc = cyc;
    if (rises >= 48 && rises <= 63) mdio_i = phy_data[63-rises];
    else mdio_i = 1'b1;
  end

  always @(mdio_o) begin
    if (rises >= 1 && rises <= 63 && !mdc) begin
      if (cyc - fall_cyc < dmin) dmin = cyc - fall_cyc;
      if (cyc - fall_cyc > dmax) dmax = cyc - fall_cyc;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic launch(input logic [31:0] f);
    rises = 0; dmin = 99; dmax = 0; cap = '0; oecap = '0;
    wr(2'd0, f);
  endtask

  task automatic wait_event();
    int n = 0;
    while (!mii_event && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  // speed(6) hold(3) frame(32) phy reply(16)
  localparam logic [56:0] VEC [4] = '{
    {6'd4, 3'd0, 2'b01, 2'b01, 5'h01, 5'h00, 2'b10, 16'hA5C3, 16'h0000},
    {6'd3, 3'd1, 2'b01, 2'b10, 5'h1F, 5'h1F, 2'b10, 16'h0000, 16'h8001},
    {6'd1, 3'd3, 2'b01, 2'b01, 5'h00, 5'h0A, 2'b10, 16'hFFFF, 16'h0000},
    {6'd6, 3'd7, 2'b01, 2'b10, 5'h0A, 5'h15, 2'b10, 16'h1234, 16'h3C5A}
  };

  initial begin : watchdog
    while (cyc < 150000 && !finished) @(negedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset", {mdc, mdio_oe, mdio_o, mii_event, frame_q},
          {1'b0, 1'b0, 1'b1, 1'b0, 32'h0});
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      logic [5:0]  s;
      logic [2:0]  h;
      logic [31:0] f;
      logic [63:0] sh;
      int half, he;
      bit rd;
      s = VEC[i][56:51]; h = VEC[i][50:48]; f = VEC[i][47:16]; phy_data = VEC[i][15:0];
      half = (s == 1) ? 2 : int'(s);
      he = (int'(h) > half - 2) ? half - 2 : int'(h);
      rd = (f[29:28] == 2'b10);
      sh = {32'hFFFF_FFFF, f};
      wr(2'd1, {21'd0, h, 2'b00, s});   // R9 config layout
      launch(f);
      wait_event();
      check("R2 rises", 64'(rises), 64'd64);
      check("R2 period", 64'(r2c - r1c), 64'(2 * half));
      check("R4 delay min", 64'(dmin), 64'(he + 1));
      check("R4 delay max", 64'(dmax), 64'(he + 1));
      check("R5 event set", 64'(mii_event), 64'd1);
      check("R8 idle", {61'd0, mdc, mdio_oe, mdio_o}, 64'd1);
      if (rd) begin
        check("R1 read header", 64'(cap[63:17]), 64'(sh[63:17]));
        check("R3 release", oecap, {{47{1'b1}}, 17'd0});
        check("R3 read data", 64'(frame_q), 64'({f[31:16], phy_data}));
      end else begin
        check("R1 write bits", cap, sh);
        check("R1 oe", oecap, {64{1'b1}});
        check("R1 frame_q", 64'(frame_q), 64'(f));
      end
      wr(2'd2, 32'h0);
      check("R5 clear bit0=0", 64'(mii_event), 64'd1);
      wr(2'd2, 32'h1);
      check("R5 clear", 64'(mii_event), 64'd0);
    end

    // R6 speed zero stalls
    wr(2'd1, 32'h0);
    launch(mk(2'b01, 5'h03, 5'h04, 16'h5A5A));
    repeat (300) @(negedge clk);
    check("R6 no mdc", {62'd0, 1'(rises != 0), mdc}, 64'd0);
    check("R6 no event", 64'(mii_event), 64'd0);
    wr(2'd1, 32'h4);
    wait_event();
    check("R6 resumed", 64'(rises), 64'd64);
    check("R6 bits", cap, {32'hFFFF_FFFF, mk(2'b01, 5'h03, 5'h04, 16'h5A5A)});
    wr(2'd2, 32'h1);

    // R7 write while busy ignored
    launch(mk(2'b01, 5'h11, 5'h02, 16'hC0DE));
    while (rises < 10) @(negedge clk);
    wr(2'd0, mk(2'b10, 5'h07, 5'h07, 16'h0000));
    check("R7 frame_q mid", 64'(frame_q), 64'(mk(2'b01, 5'h11, 5'h02, 16'hC0DE)));
    wait_event();
    check("R7 wire", cap, {32'hFFFF_FFFF, mk(2'b01, 5'h11, 5'h02, 16'hC0DE)});
    check("R7 frame_q end", 64'(frame_q), 64'(mk(2'b01, 5'h11, 5'h02, 16'hC0DE)));
    check("R7 rises", 64'(rises), 64'd64);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule